// File: doc/BRIEF.md
# Serial Break Character Generator

This block drives the transmit line of an asynchronous serial port while software asks for break characters. A break character is a run of logic-0 bit times. It is longer than any legal data frame, so a receiver reads it as a line condition and not as data. The block advances only on a one-cycle bit tick supplied from outside. It looks at the request once per bit boundary and keeps the line low for a whole number of bit times.

When the request is set and the line is free, a break starts. While the request stays set, breaks follow one another with no high bit between them. If the request drops in the middle of a break, that break still runs to its full length. The line then goes high for at least one bit time before anything else can start. The length of each break depends on the frame format (data width and parity) and on a long-break option. The format is sampled when each break character starts. A smart-card mode input blocks breaks. A data-busy input holds a pending break back until the data character in flight has sent its stop bit.

Top module: `brk_tx_top`

## Requirements
- R1: After reset, the line is high (idle) and the busy output is low.
- R2: With long-break low, a break lasts 10 bit times for nineBit=0 and parityOn=0, 11 bit times for nineBit=1 or parityOn=1 (only one of them set), and 12 bit times for nineBit=1 and parityOn=1. The format is sampled when each break character starts.
- R3: With long-break high, a break lasts 13 bit times for nineBit=0 and 14 bit times for nineBit=1, whatever parityOn is.
- R4: While the request is held, break characters follow one another with no high bit time between them.
- R5: If the request is cleared during a break, the break still completes its full length. After it, the line is high for at least one bit time.
- R6: While cardMode is high, no break character starts, including a back-to-back one at a character boundary.
- R7: While dataBusy is high, a pending break does not start. It starts at the first bit tick on which dataBusy is low.
- R8: The busy output is high exactly during break bit times. The line and busy change only on the clock edge that samples bitTick high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle strobe marking each bit boundary |
| sendBreak | input | 1 | 1 = queue break characters, 0 = normal operation |
| longBreak | input | 1 | Selects the long break lengths |
| nineBit | input | 1 | Frame carries 9 data bits |
| parityOn | input | 1 | Frame carries a parity bit |
| cardMode | input | 1 | Smart-card mode; blocks breaks |
| dataBusy | input | 1 | A data character is on the line |
| txLine | output | 1 | Serial output, idle high |
| breakBusy | output | 1 | High while a break bit is being driven |

## Verification
All four short-format combinations and both long-format widths are driven. Each one tells apart the 10, 11, 12, 13 and 14 bit counts. The request is held across several characters to separate back-to-back chaining from a gap-then-restart. It is also dropped early, late and on the final bit, which shows that every break completes and is followed by one high bit. Format changes in the middle of a hold show that the length is sampled once per character. Card mode and data busy are raised at character boundaries and while idle, which shows blocking and deferral apart from a plain absent request.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    stIdle  = 2'd0,
    stBreak = 2'd1,
    stGap   = 2'd2
  } brkState_t;

  typedef struct packed {
    logic load;
    logic dec;
  } brkStrobe_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath import brk_pkg::*; #(
  parameter int ShortBase = 10,
  parameter int LongBase  = 13,
  parameter int MaxLen    = 14,
  localparam int CntW     = $clog2(MaxLen)
) (
  input  logic       clk,
  input  logic       rstN,
  input  brkStrobe_t strobe,
  input  logic       longBreak,
  input  logic       nineBit,
  input  logic       parityOn,
  output logic       lastBit
);
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] loadVal;

  always_comb begin
    if (longBreak)
      loadVal = CntW'(LongBase - 1 + int'(nineBit));
    else
      loadVal = CntW'(ShortBase - 1 + int'(nineBit) + int'(parityOn));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strobe.load) cnt <= loadVal;
    else if (strobe.dec)  cnt <= cnt - 1'b1;
  end

  assign lastBit = (cnt == '0);

  // R2 / R3: a freshly loaded count lies in the legal length range
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt >= CntW'(ShortBase - 1)) && (cnt <= CntW'(MaxLen - 1)));

  // R2: long-break low never loads a long count
  a_r2_short_max: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !longBreak) |=> cnt <= CntW'(ShortBase + 1));
endmodule

// File: rtl/brk_control.sv
module brk_control import brk_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       sendBreak,
  input  logic       cardMode,
  input  logic       dataBusy,
  input  logic       lastBit,
  output brkStrobe_t strobe,
  output logic       txLine,
  output logic       breakBusy
);
  brkState_t state, stateNext;
  logic      reqOk;

  assign reqOk = sendBreak && !cardMode;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.dec  = 1'b0;
    if (bitTick) begin
      unique case (state)
        stIdle: if (reqOk && !dataBusy) begin
          stateNext   = stBreak;
          strobe.load = 1'b1;
        end
        stBreak: begin
          if (!lastBit)   strobe.dec = 1'b1;
          else if (reqOk) strobe.load = 1'b1;
          else            stateNext = stGap;
        end
        stGap:   stateNext = stIdle;
        default: stateNext = stIdle;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= stIdle;
    else       state <= stateNext;
  end

  assign txLine    = (state != stBreak);
  assign breakBusy = (state == stBreak);

  a_r6_card_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (state == stIdle && cardMode) |=> state != stBreak);

  a_r7_wait_data: assert property (@(posedge clk) disable iff (!rstN)
    (state == stIdle && dataBusy) |=> state != stBreak);

  a_r5_gap_after: assert property (@(posedge clk) disable iff (!rstN)
    (state == stBreak && lastBit && bitTick && !sendBreak) |=> (state == stGap && txLine));

  a_r4_chain: assert property (@(posedge clk) disable iff (!rstN)
    (state == stBreak && lastBit && bitTick && reqOk) |=> breakBusy);

  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> ($stable(txLine) && $stable(breakBusy)));
endmodule

// File: rtl/brk_tx_top.sv
module brk_tx_top import brk_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic sendBreak,
  input  logic longBreak,
  input  logic nineBit,
  input  logic parityOn,
  input  logic cardMode,
  input  logic dataBusy,
  output logic txLine,
  output logic breakBusy
);
  brkStrobe_t strobe;
  logic       lastBit;

  brk_control u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .sendBreak(sendBreak),
    .cardMode(cardMode), .dataBusy(dataBusy), .lastBit(lastBit),
    .strobe(strobe), .txLine(txLine), .breakBusy(breakBusy)
  );

  brk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .longBreak(longBreak),
    .nineBit(nineBit), .parityOn(parityOn), .lastBit(lastBit)
  );
endmodule

// File: tb/test_brk_tx_top.sv
module test_brk_tx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic sendBreak = 1'b0, longBreak = 1'b0, nineBit = 1'b0, parityOn = 1'b0;
  logic cardMode = 1'b0, dataBusy = 1'b0;
  logic txLine, breakBusy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tickDiv = 0;
  string curReq = "R1";

  int remain = 0;
  bit inGap = 0;

  always #2 clk = ~clk;

  brk_tx_top i_brk_tx_top (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .sendBreak(sendBreak),
    .longBreak(longBreak), .nineBit(nineBit), .parityOn(parityOn),
    .cardMode(cardMode), .dataBusy(dataBusy), .txLine(txLine), .breakBusy(breakBusy)
  );

  function automatic int refLen();
    if (longBreak) return 13 + int'(nineBit);
    return 10 + int'(nineBit) + int'(parityOn);
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      remain = 0; inGap = 0;
    end else if (bitTick) begin
      if (remain > 0) begin
        remain = remain - 1;
        if (remain == 0) begin
          if (sendBreak && !cardMode) remain = refLen();
          else inGap = 1;
        end
      end else if (inGap) begin
        inGap = 0;
      end else if (sendBreak && !cardMode && !dataBusy) begin
        remain = refLen();
      end
    end
  end

  // compare and drive the tick away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (txLine !== (remain == 0) || breakBusy !== (remain > 0)) begin
        fails++;
        $display("FAIL %s cycle %0d: line=%b busy=%b expected line=%b busy=%b",
                 curReq, cycles, txLine, breakBusy, remain == 0, remain > 0);
      end
    end
    tickDiv = (tickDiv == 3) ? 0 : tickDiv + 1;
    bitTick = (tickDiv == 0);
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitBits(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic setFmt(input logic lb, input logic nb, input logic po);
    longBreak = lb; nineBit = nb; parityOn = po;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    checks++;
    if (txLine !== 1'b1 || breakBusy !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: line=%b busy=%b expected 1 0", txLine, breakBusy);
    end
    waitBits(3);

    curReq = "R2";
    for (int f = 0; f < 4; f++) begin
      setFmt(1'b0, f[1], f[0]);
      sendBreak = 1'b1; waitBits(2);
      sendBreak = 1'b0; waitBits(16);
    end

    curReq = "R3";
    for (int f = 0; f < 4; f++) begin
      setFmt(1'b1, f[1], f[0]);
      sendBreak = 1'b1; waitBits(3);
      sendBreak = 1'b0; waitBits(18);
    end

    curReq = "R4";
    setFmt(1'b0, 1'b0, 1'b0);
    sendBreak = 1'b1; waitBits(15);
    setFmt(1'b1, 1'b1, 1'b0); waitBits(20);
    setFmt(1'b0, 1'b1, 1'b1); waitBits(25);

    curReq = "R5";
    sendBreak = 1'b0; waitBits(20);
    setFmt(1'b0, 1'b0, 1'b1);
    sendBreak = 1'b1; waitBits(10);
    sendBreak = 1'b0; waitBits(4);
    sendBreak = 1'b1; waitBits(30);
    sendBreak = 1'b0; waitBits(18);

    curReq = "R6";
    cardMode = 1'b1; sendBreak = 1'b1; waitBits(20);
    cardMode = 1'b0; waitBits(5);
    cardMode = 1'b1; waitBits(20);
    cardMode = 1'b0; sendBreak = 1'b0; waitBits(18);

    curReq = "R7";
    dataBusy = 1'b1; sendBreak = 1'b1; waitBits(9);
    dataBusy = 1'b0; waitBits(3);
    dataBusy = 1'b1; waitBits(25);
    sendBreak = 1'b0; waitBits(18);
    dataBusy = 1'b0;

    curReq = "R8";
    setFmt(1'b1, 1'b0, 1'b0);
    sendBreak = 1'b1; repeat (7) @(negedge clk);
    sendBreak = 1'b0; waitBits(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule